// File: doc/BRIEF.md
# Event interrupt, halt and reset controller

This block gathers event pulses from a pair of serial bus engines (two engines, each with two command queues) into one sticky status word. A mask word selects which status bits may raise the single level interrupt. Software reads the status word, stages the bits it wants to drop by writing ones to a clear register, and then commits the staged clear by writing 1 to a commit register. Nothing is dropped until the commit.

The block also accepts halt requests for either engine and reset commands carrying a bit mask. Each accepted request sends a one-cycle strobe toward the engines. After a fixed, parameterised number of cycles it sets an acknowledge bit in the same status word, so that completion is signalled through the normal interrupt path. The engines themselves are not part of the block. They appear only as event input pulses and as the halt and reset strobes.

Word registers are selected by a 3-bit address: 0 status (read), 1 mask (read/write), 2 clear staging (write), 3 commit (write, bit 0), 4 halt request (write), 5 reset command (write). All other addresses read as zero.

Top module: `evt_irq_ctl`

## Requirements
- R1: Status bit positions:
  - Engine 0: read done at bit 0, queue 0 report at bit 4, queue 1 report at bit 8.
  - Engine 1: read done at bit 12, queue 0 report at bit 16, queue 1 report at bit 20.
  - Acknowledges: reset-done at bit 24, engine 0 halt at bit 25, engine 1 halt at bit 26.
  - NACK errors: bits 27 and 28 for engine 0 queues 0 and 1, bits 29 and 30 for engine 1 queues 0 and 1.
  - Other error bits: 1, 2, 5, 6, 7, 9, 10 and 11 for engine 0; 13, 14, 17, 18, 19, 21, 22 and 23 for engine 1.
  - Event-input behaviour: a one on `event_i` at any bit in 32'h78FF7FF7 sets that status bit at the next clock edge, and the bit stays set. Event bits 3, 15, 24, 25, 26 and 31 are ignored.
- R2: `irq_o` is high exactly when some status bit is set whose mask bit is also set. The mask register keeps only bits in 32'h7FFF7FF7, and reading it back returns those bits.
- R3: A write to the clear register changes no status bit by itself. A commit write with bit 0 = 1 clears the staged bits and empties the staging register. A commit write with bit 0 = 0 has no effect.
- R4: When an event arrives in the same cycle as a commit that clears its bit, the bit stays set.
- R5: Writing the halt register with bit 0 (engine 0) or bit 1 (engine 1) set pulses the matching `halt_stb_o` bit for one cycle after the write edge. The matching halt acknowledge bit (25 or 26) is set HALT_LAT edges after the write edge.
- R6: A halt request for an engine whose halt is still pending produces no strobe, and no second acknowledge is produced for it.
- R7: A reset-command write drives `reset_stb_o` with the written word ANDed with 32'h0F73F3F7 for one cycle. Examples: 32'h000003F1 targets engine 0 only, and 32'h0003F001 targets engine 1 only. Bit 24 is set RST_LAT edges after the write edge. A command written while a reset is pending is ignored.
- R8: A reset-command word with no bit inside 32'h0F73F3F7 produces no strobe and no acknowledge.
- R9: `err_o[0]` is high when any status bit in 32'h18000EE6 is set, and `err_o[1]` is high when any status bit in 32'h60EE6000 is set. Both are independent of the mask.
- R10: After reset, status, mask, staging, `irq_o`, `err_o` and both strobes are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we_i | input | 1 | Register write enable |
| reg_addr_i | input | 3 | Register select |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for the selected register |
| event_i | input | 32 | Event pulses from the engines |
| irq_o | output | 1 | Level interrupt |
| err_o | output | 2 | Per-engine error summary |
| halt_stb_o | output | 2 | Per-engine halt strobe |
| reset_stb_o | output | 32 | Reset strobe carrying the accepted mask |

## Verification
The bench targets four corner cases:
- An event that coincides with the commit of its own clear. A design that applies the clear last would lose the event.
- A clear write without a commit. An eager design would drop status early.
- A second halt issued while the first is pending. A design without a busy guard would strobe twice or acknowledge twice.
- A reset word that falls entirely outside the valid mask. A careless design would still acknowledge it.

Acknowledge timing is checked at the exact edge, so an off-by-one latency counter fails. A behavioural model run alongside catches any cycle where the interrupt, error, strobe or read outputs diverge.

// File: rtl/evt_irq_pkg.sv
package evt_irq_pkg;
  localparam int unsigned EW = 32;
  localparam int unsigned AW = 3;
  localparam int unsigned NUM_ENG = 2;

  localparam logic [EW-1:0] IMPL_BITS   = 32'h7FFF_7FF7;
  localparam logic [EW-1:0] EXT_EV_BITS = 32'h78FF_7FF7;
  localparam logic [EW-1:0] ENG0_ERR    = 32'h1800_0EE6;
  localparam logic [EW-1:0] ENG1_ERR    = 32'h60EE_6000;
  localparam logic [EW-1:0] RST_VALID   = 32'h0F73_F3F7;

  localparam int unsigned RST_ACK_POS  = 24;
  localparam int unsigned HALT_ACK_POS = 25;

  typedef enum logic [AW-1:0] {
    SEL_STATUS = 3'd0,
    SEL_MASK   = 3'd1,
    SEL_CLEAR  = 3'd2,
    SEL_COMMIT = 3'd3,
    SEL_HALT   = 3'd4,
    SEL_RESET  = 3'd5
  } reg_sel_e;
endpackage

// File: rtl/evt_ack_timer.sv
module evt_ack_timer #(
  parameter int unsigned LAT = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW = (LAT < 2) ? 1 : $clog2(LAT + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          busy_q, busy_d;
  logic          en;

  always_comb begin
    busy_d = busy_q;
    cnt_d  = cnt_q;
    if (busy_q) begin
      if (cnt_q == '0) busy_d = 1'b0;
      else             cnt_d  = cnt_q - 1'b1;
    end else if (start_i) begin
      busy_d = 1'b1;
      cnt_d  = CW'(LAT - 1);
    end
  end

  assign en = busy_q | start_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (en) begin
      busy_q <= busy_d;
      cnt_q  <= cnt_d;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  // R6: a pending request keeps counting down and cannot be restarted
  a_r6_countdown_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && cnt_q != '0) |=> (busy_q && cnt_q == CW'($past(cnt_q) - 1'b1)));

  // R5: each request produces exactly one completion
  a_r5_single_done: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !busy_q);
endmodule

// File: rtl/evt_status_bank.sv
module evt_status_bank
  import evt_irq_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [EW-1:0] set_i,
  input  logic          stage_we_i,
  input  logic [EW-1:0] stage_data_i,
  input  logic          commit_i,
  output logic [EW-1:0] status_o
);
  logic [EW-1:0] status_q, status_d;
  logic [EW-1:0] stage_q, stage_d;
  logic [EW-1:0] drop;
  logic [EW-1:0] set_m;
  logic          stage_en;

  assign set_m = set_i & IMPL_BITS;
  assign drop  = commit_i ? stage_q : '0;

  always_comb begin
    status_d = (status_q & ~drop) | set_m;
  end

  always_comb begin
    stage_d = stage_q;
    if (commit_i)   stage_d = '0;
    if (stage_we_i) stage_d = stage_data_i & IMPL_BITS;
  end

  assign stage_en = commit_i | stage_we_i;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status_q <= '0;
    else        status_q <= status_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        stage_q <= '0;
    else if (stage_en) stage_q <= stage_d;
  end

  assign status_o = status_q;

  // R4: an arriving event is always present after the edge
  a_r4_event_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((status_q & $past(set_m)) == $past(set_m)));

  // R3: without a commit no status bit falls
  a_r3_no_drop_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ((status_q & $past(status_q)) == $past(status_q)));
endmodule

// File: rtl/evt_irq_ctl.sv
module evt_irq_ctl
  import evt_irq_pkg::*;
#(
  parameter int unsigned HALT_LAT = 5,
  parameter int unsigned RST_LAT  = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we_i,
  input  logic [AW-1:0] reg_addr_i,
  input  logic [EW-1:0] reg_wdata_i,
  output logic [EW-1:0] reg_rdata_o,
  input  logic [EW-1:0] event_i,
  output logic          irq_o,
  output logic [1:0]    err_o,
  output logic [NUM_ENG-1:0] halt_stb_o,
  output logic [EW-1:0] reset_stb_o
);
  logic wr_mask, wr_clear, wr_commit, wr_halt, wr_reset;
  logic [EW-1:0] mask_q;
  logic [EW-1:0] status;
  logic [EW-1:0] ack_set, set_vec;
  logic [NUM_ENG-1:0] halt_req, halt_busy, halt_done;
  logic [NUM_ENG-1:0] halt_stb_q, halt_stb_d;
  logic [EW-1:0] rst_bits, reset_stb_q, reset_stb_d;
  logic rst_req, rst_busy, rst_done;

  assign wr_mask   = reg_we_i && (reg_addr_i == SEL_MASK);
  assign wr_clear  = reg_we_i && (reg_addr_i == SEL_CLEAR);
  assign wr_commit = reg_we_i && (reg_addr_i == SEL_COMMIT) && reg_wdata_i[0];
  assign wr_halt   = reg_we_i && (reg_addr_i == SEL_HALT);
  assign wr_reset  = reg_we_i && (reg_addr_i == SEL_RESET);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (wr_mask) mask_q <= reg_wdata_i & IMPL_BITS;
  end

  genvar g;
  for (g = 0; g < NUM_ENG; g++) begin : g_halt
    assign halt_req[g]   = wr_halt && reg_wdata_i[g];
    assign halt_stb_d[g] = halt_req[g] && !halt_busy[g];
    evt_ack_timer #(.LAT(HALT_LAT)) u_halt_tmr (
      .clk    (clk),
      .rst_n  (rst_n),
      .start_i(halt_req[g]),
      .busy_o (halt_busy[g]),
      .done_o (halt_done[g])
    );
  end

  assign rst_bits    = reg_wdata_i & RST_VALID;
  assign rst_req     = wr_reset && (rst_bits != '0);
  assign reset_stb_d = (rst_req && !rst_busy) ? rst_bits : '0;

  evt_ack_timer #(.LAT(RST_LAT)) u_rst_tmr (
    .clk    (clk),
    .rst_n  (rst_n),
    .start_i(rst_req),
    .busy_o (rst_busy),
    .done_o (rst_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halt_stb_q  <= '0;
      reset_stb_q <= '0;
    end else begin
      halt_stb_q  <= halt_stb_d;
      reset_stb_q <= reset_stb_d;
    end
  end

  always_comb begin
    ack_set = '0;
    ack_set[RST_ACK_POS] = rst_done;
    for (int m = 0; m < NUM_ENG; m++) ack_set[HALT_ACK_POS + m] = halt_done[m];
  end

  assign set_vec = (event_i & EXT_EV_BITS) | ack_set;

  evt_status_bank u_bank (
    .clk         (clk),
    .rst_n       (rst_n),
    .set_i       (set_vec),
    .stage_we_i  (wr_clear),
    .stage_data_i(reg_wdata_i),
    .commit_i    (wr_commit),
    .status_o    (status)
  );

  always_comb begin
    case (reg_addr_i)
      SEL_STATUS: reg_rdata_o = status;
      SEL_MASK:   reg_rdata_o = mask_q;
      default:    reg_rdata_o = '0;
    endcase
  end

  assign irq_o       = |(status & mask_q);
  assign err_o[0]    = |(status & ENG0_ERR);
  assign err_o[1]    = |(status & ENG1_ERR);
  assign halt_stb_o  = halt_stb_q;
  assign reset_stb_o = reset_stb_q;

  // R6: a halt strobe is never followed by a second one on the same engine
  a_r6_halt_no_back_to_back: assert property (@(posedge clk) disable iff (!rst_n)
    (|halt_stb_o) |=> ((halt_stb_o & $past(halt_stb_o)) == '0));

  // R7: a reset strobe is a single-cycle pulse
  a_r7_reset_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (|reset_stb_o) |=> (reset_stb_o == '0));

  // R2: with nothing masked in, the line stays low
  a_r2_quiet_when_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '0) |-> !irq_o);

  // R7: reset acknowledge appears only when the reset timer completes
  a_r7_ack_from_timer: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(status[RST_ACK_POS]) |-> $past(rst_done));
endmodule

// File: tb/evt_irq_ctl_tb_top.sv
module evt_irq_ctl_tb_top;
  localparam int HL = 5;
  localparam int RL = 8;
  localparam logic [31:0] IMPL = 32'h7FFF7FF7;
  localparam logic [31:0] EXTV = 32'h78FF7FF7;
  localparam logic [31:0] RSTV = 32'h0F73F3F7;

  logic clk, rst_n, we;
  logic [2:0]  addr;
  logic [31:0] wdata, rdata, ev, rstb;
  logic irq;
  logic [1:0] err, hstb;
  int checks = 0, errors = 0;

  evt_irq_ctl #(.HALT_LAT(HL), .RST_LAT(RL)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we_i(we), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .event_i(ev),
    .irq_o(irq), .err_o(err), .halt_stb_o(hstb), .reset_stb_o(rstb));

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] m_st, m_mask, m_stage, m_rstb;
  logic [1:0]  m_hstb;
  int m_hc[2];
  int m_rc;

  function automatic logic [31:0] m_read(logic [2:0] a);
    if (a == 3'd0) return m_st;
    if (a == 3'd1) return m_mask;
    return 32'h0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_st = 0; m_mask = 0; m_stage = 0; m_rstb = 0; m_hstb = 0;
      m_hc[0] = 0; m_hc[1] = 0; m_rc = 0;
    end else begin
      logic [31:0] setv, drop;
      logic [1:0] hbusy;
      logic rbusy;
      chk("R2 irq", {31'b0, irq}, {31'b0, |(m_st & m_mask)});
      chk("R9 err", {30'b0, err}, {30'b0, |(m_st & 32'h60EE6000), |(m_st & 32'h18000EE6)});
      chk("R5 halt strobe", {30'b0, hstb}, {30'b0, m_hstb});
      chk("R7 reset strobe", rstb, m_rstb);
      chk("R1 read data", rdata, m_read(addr));
      setv = ev & EXTV;
      drop = 0;
      for (int m = 0; m < 2; m++) begin
        hbusy[m] = (m_hc[m] > 0);
        if (m_hc[m] > 0) begin
          m_hc[m]--;
          if (m_hc[m] == 0) setv[25+m] = 1'b1;
        end
      end
      rbusy = (m_rc > 0);
      if (m_rc > 0) begin
        m_rc--;
        if (m_rc == 0) setv[24] = 1'b1;
      end
      m_hstb = 0;
      m_rstb = 0;
      if (we) begin
        case (addr)
          3'd1: m_mask = wdata & IMPL;
          3'd2: m_stage = wdata & IMPL;
          3'd3: if (wdata[0]) begin drop = m_stage; m_stage = 0; end
          3'd4: for (int m = 0; m < 2; m++)
                  if (wdata[m] && !hbusy[m]) begin m_hc[m] = HL; m_hstb[m] = 1'b1; end
          3'd5: if (((wdata & RSTV) != 0) && !rbusy) begin m_rc = RL; m_rstb = wdata & RSTV; end
          default: ;
        endcase
      end
      m_st = (m_st & ~drop) | setv;
    end
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    we = 1'b0; addr = 3'd0; wdata = 0;
    #1;
  endtask

  task automatic pulse(logic [31:0] v);
    ev = v;
    @(negedge clk);
    ev = 0;
    #1;
  endtask

  task automatic clear_all();
    @(negedge clk); wr(3'd2, 32'hFFFFFFFF);
    @(negedge clk); wr(3'd3, 32'h1);
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #800000;
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; we = 0; addr = 0; wdata = 0; ev = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R10 reset state
    chk("R10 status", rdata, 32'h0);
    chk("R10 irq", {31'b0, irq}, 32'h0);
    chk("R10 strobes", rstb | {30'b0, hstb}, 32'h0);
    chk("R10 err", {30'b0, err}, 32'h0);

    @(negedge clk); wr(3'd1, 32'hFFFFFFFF);
    addr = 3'd1; #1;
    chk("R2 mask readback", rdata, 32'h7FFF7FF7);
    addr = 3'd0;

    @(negedge clk); pulse(32'hFFFFFFFF);
    chk("R1 status all events", rdata, 32'h78FF7FF7);
    chk("R2 irq raised", {31'b0, irq}, 32'h1);
    chk("R9 both error groups", {30'b0, err}, 32'h3);

    @(negedge clk); wr(3'd2, 32'h78FF7FF7);
    chk("R3 staged only", rdata, 32'h78FF7FF7);
    @(negedge clk); wr(3'd3, 32'h0);
    chk("R3 commit bit0 low", rdata, 32'h78FF7FF7);
    @(negedge clk); wr(3'd3, 32'h1);
    chk("R3 commit clears", rdata, 32'h0);
    chk("R2 irq dropped", {31'b0, irq}, 32'h0);

    @(negedge clk); pulse(32'h1);
    @(negedge clk); wr(3'd3, 32'h1);
    chk("R3 staging emptied", rdata, 32'h1);
    clear_all();

    @(negedge clk); pulse(32'h11);
    @(negedge clk); wr(3'd2, 32'h11);
    @(negedge clk);
    ev = 32'h10;
    wr(3'd3, 32'h1);
    ev = 0;
    chk("R4 event beats clear", rdata, 32'h10);
    clear_all();

    @(negedge clk); wr(3'd1, 32'h0);
    @(negedge clk); pulse(32'h20000000);
    chk("R9 engine1 nack", {30'b0, err}, 32'h2);
    chk("R2 masked off", {31'b0, irq}, 32'h0);
    clear_all();
    @(negedge clk); pulse(32'h00000002);
    chk("R9 engine0 error", {30'b0, err}, 32'h1);
    clear_all();
    @(negedge clk); pulse(32'h8700_8008);
    chk("R1 ignored event bits", rdata, 32'h0);

    @(negedge clk); wr(3'd1, 32'h02000000);
    @(negedge clk); wr(3'd4, 32'h1);
    chk("R5 halt strobe engine0", {30'b0, hstb}, 32'h1);
    wr(3'd4, 32'h1);
    chk("R6 no strobe while pending", {30'b0, hstb}, 32'h0);
    repeat (HL - 2) @(negedge clk);
    #1;
    chk("R5 ack not early", rdata, 32'h0);
    @(negedge clk); #1;
    chk("R5 ack on time", rdata, 32'h02000000);
    chk("R5 irq from ack", {31'b0, irq}, 32'h1);
    repeat (HL + 2) @(negedge clk);
    #1;
    chk("R6 single ack", rdata, 32'h02000000);
    clear_all();

    @(negedge clk); wr(3'd4, 32'h3);
    chk("R5 both strobes", {30'b0, hstb}, 32'h3);
    repeat (HL) @(negedge clk);
    #1;
    chk("R5 both acks", rdata, 32'h06000000);
    clear_all();

    @(negedge clk); wr(3'd5, 32'h000003F1);
    chk("R7 engine0 reset strobe", rstb, 32'h000003F1);
    repeat (RL - 1) @(negedge clk);
    #1;
    chk("R7 ack not early", rdata, 32'h0);
    @(negedge clk); #1;
    chk("R7 reset ack", rdata, 32'h01000000);
    clear_all();
    @(negedge clk); wr(3'd5, 32'hFFFFFFFF);
    chk("R7 full reset strobe", rstb, 32'h0F73F3F7);
    repeat (RL + 1) @(negedge clk);
    clear_all();
    @(negedge clk); wr(3'd5, 32'hF0000008);
    chk("R8 no strobe", rstb, 32'h0);
    repeat (RL + 2) @(negedge clk);
    #1;
    chk("R8 no ack", rdata, 32'h0);

    repeat (2) @(negedge clk);
    finish_run();
  end
endmodule